// File: doc/BRIEF.md
# Handshaked Byte Command Engine

This block is the device side of a byte-serial command link. A host and the engine pass bytes through a shift-data byte. Two active-low lines in an eight-bit port word pace the transfer: a request line driven by the host and an acknowledge line driven by the engine. Each time the host writes the port word, the engine decodes the two lines. When the host makes a valid request, the engine takes or supplies one byte and pulses a shift-done strobe.

A transaction starts with a command byte. An internal length table then tells the engine how many argument bytes follow and how many response bytes go back. A table entry may be marked variable. In that case the host sends the argument count as the first byte after the command, or the engine sends the response size as the first byte of the response. Once all argument bytes have arrived, the engine presents the command and the arguments on a dispatch port. An external handler answers in the same cycle, and the engine latches the answer and returns it one byte per handshake.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset, portb_o is 8'h18 (request bit 4 and acknowledge bit 3 both high, all other bits low), sr_done_o is 0, sr_data_o is 0 and the sequencer is idle.
- R2: A port write whose value equals the current portb_o has no effect: portb_o is unchanged and no byte is handled.
- R3: A changed write with bit 4 high and bit 3 low is an acknowledge release. portb_o takes the written value with bit 3 forced high, and no byte is handled.
- R4: A changed write with bits 4 and 3 equal (both high for idle, or both low for invalid) is copied to portb_o unchanged. No byte is handled and the sequencer state does not change.
- R5: A changed write with bit 4 low and bit 3 high is a request. portb_o takes the value with bit 3 driven low, and sr_done_o pulses for one cycle after each byte the engine handles.
- R6: In idle, a request with sr_dir_out_i=1 loads sr_data_i as the command, clears the argument buffer and both position counts, and starts argument collection. A command whose table entry has zero arguments is dispatched on that same byte.
- R7: With a fixed argument count, argument bytes are stored in arrival order (byte 0 in disp_args_o[7:0]). The command is dispatched on the byte that brings the stored count up to the table count. Bytes beyond 32 are dropped.
- R8: With a variable argument count, the first byte after the command sets the count, and the bytes after it are stored as arguments.
- R9: In the response phase, requests with sr_dir_out_i=0 place the response bytes on sr_data_o in order. The engine returns to idle after the last byte, or straight after dispatch when the response length is zero.
- R10: With a variable response length, the first response byte is the size reported by the handler (clamped to 32), and that many bytes follow.
- R11: A request whose direction does not match the phase (host-to-device in response, device-to-host in idle or argument collection) handles no byte and leaves the sequencer state and counts unchanged. The acknowledge line is still driven low.
- R12: When disp_known_i is 0, the response is the table length of zero bytes, or empty (size byte 0) when the table length is variable.
- R13: Table entries (arguments/response, V = variable): 8'h10 1/0, 8'h20 V/V, 8'h30 4/0, 8'h38 0/4, 8'h48 0/V, 8'h5A 0/2, 8'h6B 0/V, 8'h78 0/1. Every other command is 0/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| portb_wr_i | input | 1 | Host write strobe for the port word |
| portb_i | input | 8 | Port word written by the host |
| portb_o | output | 8 | Current port word, including the engine's acknowledge bit |
| sr_dir_out_i | input | 1 | Shift direction: 1 host-to-device, 0 device-to-host |
| sr_data_i | input | 8 | Byte shifted in by the host |
| sr_data_o | output | 8 | Byte loaded for the host to shift out |
| sr_done_o | output | 1 | One-cycle pulse per handled byte |
| disp_valid_o | output | 1 | Dispatch strobe, combinational within the completing cycle |
| disp_cmd_o | output | 8 | Command being dispatched |
| disp_arg_cnt_o | output | 8 | Number of stored argument bytes |
| disp_args_o | output | 256 | Argument buffer, byte i at bits [8i+7:8i] |
| disp_known_i | input | 1 | Handler recognises the command |
| disp_rsp_len_i | input | 8 | Handler response size for variable-length responses |
| disp_rsp_i | input | 256 | Handler response bytes, byte i at bits [8i+7:8i] |

## Verification
The main flow is driven with commands that cover every table shape: no arguments with a fixed response, a fixed argument count with no response, a variable count in both directions, and a variable response only. A mix-up between the fixed and variable paths therefore shows up as a missing or extra size byte. The handler returns each argument XOR-ed with an index-dependent constant, so byte ordering, argument placement and stale buffer contents each produce different wrong values. Unknown commands with a fixed and a variable table entry separate zero fill from an empty response. Directed sequences cover rewrites of the same port value, the invalid and idle line states, and requests with the wrong direction in idle and in the response phase. Each of these is followed by a full transaction that shows the sequencer kept its place.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int REQ_BIT = 4;
  localparam int ACK_BIT = 3;
  localparam logic [7:0] ACK_MASK = 8'(1 << ACK_BIT);
  localparam logic [7:0] PORT_RST = 8'((1 << REQ_BIT) | (1 << ACK_BIT));

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_RSP} seq_st_e;

  typedef struct packed {
    logic       arg_var;
    logic [7:0] arg_len;
    logic       rsp_var;
    logic [7:0] rsp_len;
  } len_ent_t;

  function automatic len_ent_t len_entry(input logic [7:0] c);
    len_ent_t e;
    e = '0;
    unique case (c)
      8'h10: e.arg_len = 8'd1;
      8'h20: begin e.arg_var = 1'b1; e.rsp_var = 1'b1; end
      8'h30: e.arg_len = 8'd4;
      8'h38: e.rsp_len = 8'd4;
      8'h48: e.rsp_var = 1'b1;
      8'h5A: e.rsp_len = 8'd2;
      8'h6B: e.rsp_var = 1'b1;
      8'h78: e.rsp_len = 8'd1;
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/cmd_len_rom.sv
module cmd_len_rom
  import hs_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [IW-1:0] idx_i,
  output len_ent_t      ent_o
);
  len_ent_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign rom[g] = len_entry(8'(g));
  end

  assign ent_o = rom[idx_i];
endmodule

// File: rtl/hs_decode.sv
module hs_decode
  import hs_pkg::*;
(
  input  logic       wr_i,
  input  logic [7:0] new_i,
  input  logic [7:0] cur_i,
  output logic       req_o,
  output logic       rel_o,
  output logic       plain_o
);
  logic changed;
  assign changed = wr_i && (new_i != cur_i);

  always_comb begin
    req_o   = 1'b0;
    rel_o   = 1'b0;
    plain_o = 1'b0;
    if (changed) begin
      unique case ({new_i[REQ_BIT], new_i[ACK_BIT]})
        2'b10:   rel_o   = 1'b1;
        2'b01:   req_o   = 1'b1;
        default: plain_o = 1'b1;  // idle or invalid: copy only
      endcase
    end
  end
endmodule

// File: rtl/byte_sel.sv
module byte_sel #(
  parameter int NBYTES = 32
) (
  input  logic [NBYTES*8-1:0] buf_i,
  input  logic [7:0]          idx_i,
  output logic [7:0]          byte_o
);
  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (idx_i == 8'(i)) byte_o = buf_i[i*8 +: 8];
    end
  end
endmodule

// File: rtl/hs_cmd_engine.sv
module hs_cmd_engine
  import hs_pkg::*;
#(
  parameter int ARG_BYTES = 32,
  parameter int RSP_BYTES = 32,
  parameter int TBL_DEPTH = 256,
  localparam int ARG_W = ARG_BYTES * 8,
  localparam int RSP_W = RSP_BYTES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             portb_wr_i,
  input  logic [7:0]       portb_i,
  output logic [7:0]       portb_o,
  input  logic             sr_dir_out_i,
  input  logic [7:0]       sr_data_i,
  output logic [7:0]       sr_data_o,
  output logic             sr_done_o,
  output logic             disp_valid_o,
  output logic [7:0]       disp_cmd_o,
  output logic [7:0]       disp_arg_cnt_o,
  output logic [ARG_W-1:0] disp_args_o,
  input  logic             disp_known_i,
  input  logic [7:0]       disp_rsp_len_i,
  input  logic [RSP_W-1:0] disp_rsp_i
);
  localparam int TIW = $clog2(TBL_DEPTH);

  logic [7:0]       pb_q, pb_d;
  seq_st_e          st_q, st_d;
  logic [7:0]       cmd_q, cmd_d;
  logic             arg_var_q, arg_var_d, rsp_var_q, rsp_var_d;
  logic [7:0]       arg_len_q, arg_len_d, rsp_len_q, rsp_len_d;
  logic [7:0]       arg_pos_q, arg_pos_d, rsp_pos_q, rsp_pos_d;
  logic [7:0]       rsp_sz_q, rsp_sz_d;
  logic [ARG_W-1:0] args_q, args_d;
  logic [RSP_W-1:0] rsp_q, rsp_d;
  logic [7:0]       sro_q, sro_d;
  logic             done_q, done_d;
  logic             fire;

  logic     ev_req, ev_rel, ev_plain;
  len_ent_t ent;
  logic [7:0] rsp_byte, var_sz;

  hs_decode u_dec (
    .wr_i    (portb_wr_i),
    .new_i   (portb_i),
    .cur_i   (pb_q),
    .req_o   (ev_req),
    .rel_o   (ev_rel),
    .plain_o (ev_plain)
  );

  cmd_len_rom #(.DEPTH(TBL_DEPTH)) u_rom (
    .idx_i (sr_data_i[TIW-1:0]),
    .ent_o (ent)
  );

  byte_sel #(.NBYTES(RSP_BYTES)) u_rsel (
    .buf_i  (rsp_q),
    .idx_i  (rsp_pos_q),
    .byte_o (rsp_byte)
  );

  assign var_sz = (disp_rsp_len_i > 8'(RSP_BYTES)) ? 8'(RSP_BYTES) : disp_rsp_len_i;

  always_comb begin
    pb_d      = pb_q;
    st_d      = st_q;
    cmd_d     = cmd_q;
    arg_var_d = arg_var_q;
    arg_len_d = arg_len_q;
    rsp_var_d = rsp_var_q;
    rsp_len_d = rsp_len_q;
    arg_pos_d = arg_pos_q;
    rsp_pos_d = rsp_pos_q;
    rsp_sz_d  = rsp_sz_q;
    args_d    = args_q;
    rsp_d     = rsp_q;
    sro_d     = sro_q;
    done_d    = 1'b0;
    fire      = 1'b0;
    if (ev_rel) begin
      pb_d = portb_i | ACK_MASK;
    end else if (ev_plain) begin
      pb_d = portb_i;
    end else if (ev_req) begin
      pb_d = portb_i & ~ACK_MASK;
      unique case (st_q)
        ST_IDLE: begin
          if (sr_dir_out_i) begin
            cmd_d     = sr_data_i;
            arg_var_d = ent.arg_var;
            arg_len_d = ent.arg_len;
            rsp_var_d = ent.rsp_var;
            rsp_len_d = ent.rsp_len;
            arg_pos_d = '0;
            rsp_pos_d = '0;
            args_d    = '0;
            st_d      = ST_CMD;
            done_d    = 1'b1;
          end
        end
        ST_CMD: begin
          if (sr_dir_out_i) begin
            if (arg_var_q) begin
              arg_len_d = sr_data_i;
              arg_var_d = 1'b0;
            end else if (arg_pos_q < 8'(ARG_BYTES)) begin
              for (int i = 0; i < ARG_BYTES; i++) begin
                if (arg_pos_q == 8'(i)) args_d[i*8 +: 8] = sr_data_i;
              end
              arg_pos_d = arg_pos_q + 8'd1;
            end
            done_d = 1'b1;
          end
        end
        ST_RSP: begin
          if (!sr_dir_out_i) begin
            if (rsp_var_q) begin
              sro_d     = rsp_sz_q;
              rsp_len_d = rsp_sz_q;
              rsp_var_d = 1'b0;
            end else if (rsp_pos_q < rsp_sz_q) begin
              sro_d     = rsp_byte;
              rsp_pos_d = rsp_pos_q + 8'd1;
            end
            done_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      // completion chain: collection done -> dispatch -> maybe empty response
      if (st_d == ST_CMD && !arg_var_d && arg_len_d == arg_pos_d) begin
        fire      = 1'b1;
        st_d      = ST_RSP;
        rsp_pos_d = '0;
        if (disp_known_i) begin
          rsp_sz_d = rsp_var_d ? var_sz : rsp_len_d;
          rsp_d    = disp_rsp_i;
        end else begin
          rsp_sz_d = rsp_var_d ? 8'd0 : rsp_len_d;
          rsp_d    = '0;
        end
      end
      if (st_d == ST_RSP && !rsp_var_d && rsp_len_d == rsp_pos_d) st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pb_q      <= PORT_RST;
      st_q      <= ST_IDLE;
      cmd_q     <= '0;
      arg_var_q <= 1'b0;
      arg_len_q <= '0;
      rsp_var_q <= 1'b0;
      rsp_len_q <= '0;
      arg_pos_q <= '0;
      rsp_pos_q <= '0;
      rsp_sz_q  <= '0;
      args_q    <= '0;
      rsp_q     <= '0;
      sro_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      pb_q      <= pb_d;
      st_q      <= st_d;
      cmd_q     <= cmd_d;
      arg_var_q <= arg_var_d;
      arg_len_q <= arg_len_d;
      rsp_var_q <= rsp_var_d;
      rsp_len_q <= rsp_len_d;
      arg_pos_q <= arg_pos_d;
      rsp_pos_q <= rsp_pos_d;
      rsp_sz_q  <= rsp_sz_d;
      args_q    <= args_d;
      rsp_q     <= rsp_d;
      sro_q     <= sro_d;
      done_q    <= done_d;
    end
  end

  assign portb_o        = pb_q;
  assign sr_data_o      = sro_q;
  assign sr_done_o      = done_q;
  assign disp_valid_o   = fire;
  assign disp_cmd_o     = cmd_d;
  assign disp_arg_cnt_o = arg_pos_d;
  assign disp_args_o    = args_d;
endmodule

// File: rtl/hs_cmd_engine_chk.sv
module hs_cmd_engine_chk
  import hs_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       portb_wr_i,
  input logic [7:0] portb_i,
  input logic [7:0] portb_o,
  input logic       sr_dir_out_i,
  input logic       sr_done_o,
  input logic       disp_valid_o,
  input seq_st_e    st_q
);
  logic chg;
  assign chg = portb_wr_i && (portb_i != portb_o);

  assert_quiet_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !portb_wr_i |=> $stable(portb_o) && !sr_done_o);

  assert_same_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (portb_wr_i && portb_i == portb_o) |=> $stable(portb_o) && !sr_done_o);

  assert_ack_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && portb_i[REQ_BIT] && !portb_i[ACK_BIT]) |=> portb_o[ACK_BIT] && !sr_done_o);

  assert_plain_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && portb_i[REQ_BIT] == portb_i[ACK_BIT])
      |=> portb_o == $past(portb_i) && !sr_done_o && $stable(st_q));

  assert_request_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && !portb_i[REQ_BIT] && portb_i[ACK_BIT]) |=> !portb_o[ACK_BIT]);

  assert_done_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_done_o |-> $past(portb_wr_i) && $past(portb_i[REQ_BIT:ACK_BIT]) == 2'b01);

  assert_idle_wrong_dir_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && !portb_i[REQ_BIT] && portb_i[ACK_BIT] && st_q == ST_IDLE && !sr_dir_out_i)
      |=> st_q == ST_IDLE && !sr_done_o);

  assert_dispatch_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> st_q != ST_RSP);
endmodule

bind hs_cmd_engine hs_cmd_engine_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .portb_wr_i   (portb_wr_i),
  .portb_i      (portb_i),
  .portb_o      (portb_o),
  .sr_dir_out_i (sr_dir_out_i),
  .sr_done_o    (sr_done_o),
  .disp_valid_o (disp_valid_o),
  .st_q         (st_q)
);

// File: tb/hs_cmd_engine_bench.sv
module hs_cmd_engine_bench;
  localparam int NB = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          portb_wr = 1'b0;
  logic [7:0]    portb_in = 8'h18;
  logic [7:0]    portb_out;
  logic          sr_dir = 1'b1;
  logic [7:0]    sr_in = '0;
  logic [7:0]    sr_out;
  logic          sr_done;
  logic          d_valid;
  logic [7:0]    d_cmd, d_cnt;
  logic [NB*8-1:0] d_args, h_rsp;
  logic          h_known;
  logic [7:0]    h_len;

  int checks = 0;
  int fails = 0;
  int n_disp = 0;
  logic [7:0]      last_cmd = '0;
  logic [NB*8-1:0] last_args = '0;

  always #10 clk = ~clk;

  hs_cmd_engine u_hs_cmd_engine (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .portb_wr_i     (portb_wr),
    .portb_i        (portb_in),
    .portb_o        (portb_out),
    .sr_dir_out_i   (sr_dir),
    .sr_data_i      (sr_in),
    .sr_data_o      (sr_out),
    .sr_done_o      (sr_done),
    .disp_valid_o   (d_valid),
    .disp_cmd_o     (d_cmd),
    .disp_arg_cnt_o (d_cnt),
    .disp_args_o    (d_args),
    .disp_known_i   (h_known),
    .disp_rsp_len_i (h_len),
    .disp_rsp_i     (h_rsp)
  );

  // model handler: 8'h5A and 8'h6B unknown; byte i = arg i ^ (A0+i); size 3
  always_comb begin
    h_known = !(d_cmd == 8'h5A || d_cmd == 8'h6B);
    h_len   = 8'd3;
    for (int i = 0; i < NB; i++) h_rsp[i*8 +: 8] = d_args[i*8 +: 8] ^ (8'hA0 + 8'(i));
  end

  always @(posedge clk) if (d_valid) begin
    n_disp    <= n_disp + 1;
    last_cmd  <= d_cmd;
    last_args <= d_args;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [7:0] v);
    @(negedge clk);
    portb_wr = 1'b1;
    portb_in = v;
    @(negedge clk);
    portb_wr = 1'b0;
  endtask

  task automatic release_ack();
    wr_port(8'h10);
    chk(portb_out == 8'h18 && !sr_done, "R3", {portb_out, 7'd0, sr_done}, 32'h1800);
  endtask

  task automatic host_send(input logic [7:0] b);
    sr_dir = 1'b1;
    sr_in  = b;
    wr_port(8'h08);
    chk(portb_out == 8'h00 && sr_done, "R5", {portb_out, 7'd0, sr_done}, 32'h0001);
    release_ack();
  endtask

  task automatic host_recv(output logic [7:0] b);
    sr_dir = 1'b0;
    wr_port(8'h08);
    b = sr_out;
    chk(portb_out == 8'h00 && sr_done, "R5", {portb_out, 7'd0, sr_done}, 32'h0001);
    release_ack();
  endtask

  // {cmd, n_send, s0..s3, n_read, e0..e3}
  localparam logic [87:0] VEC [8] = '{
    {8'h78, 8'd0, 32'h0,          8'd1, 32'hA0000000},  // R9 one byte
    {8'h38, 8'd0, 32'h0,          8'd4, 32'hA0A1A2A3},  // R9 four bytes
    {8'h30, 8'd4, 32'h01020304,   8'd0, 32'h0},         // R7 fixed args
    {8'h20, 8'd3, 32'h02050600,   8'd4, 32'h03A5A7A2},  // R8 R10 both variable
    {8'h48, 8'd0, 32'h0,          8'd4, 32'h03A0A1A2},  // R10 size byte first
    {8'h5A, 8'd0, 32'h0,          8'd2, 32'h00000000},  // R12 zero fill
    {8'h6B, 8'd0, 32'h0,          8'd1, 32'h00000000},  // R12 empty
    {8'h10, 8'd1, 32'h33000000,   8'd0, 32'h0}          // R7 single arg
  };

  function automatic string vreq(input int k);
    case (k)
      0, 1:    return "R9";
      2, 7:    return "R7";
      3:       return "R8";
      4:       return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic run_vec(input logic [87:0] v, input string req);
    logic [7:0] cmd, ns, nr, b;
    int base, off;
    cmd  = v[87:80];
    ns   = v[79:72];
    nr   = v[39:32];
    base = n_disp;
    off  = (cmd == 8'h20) ? 1 : 0;
    host_send(cmd);
    for (int j = 0; j < int'(ns); j++) host_send(v[71 - j*8 -: 8]);
    chk(n_disp == base + 1 && last_cmd == cmd, "R6", {24'd0, last_cmd}, {24'd0, cmd});
    for (int j = off; j < int'(ns); j++)
      chk(last_args[(j-off)*8 +: 8] == v[71 - j*8 -: 8], req,
          {24'd0, last_args[(j-off)*8 +: 8]}, {24'd0, v[71 - j*8 -: 8]});
    for (int j = 0; j < int'(nr); j++) begin
      host_recv(b);
      chk(b == v[31 - j*8 -: 8], req, {24'd0, b}, {24'd0, v[31 - j*8 -: 8]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(portb_out == 8'h18 && !sr_done && sr_out == 8'h00 && !d_valid, "R1",
        {portb_out, sr_out, 7'd0, sr_done, 7'd0, d_valid}, 32'h18000000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(portb_out == 8'h18, "R1", {24'd0, portb_out}, 32'h18);

    foreach (VEC[k]) run_vec(VEC[k], vreq(k));

    // R2 rewrite of the same value
    wr_port(8'h18);
    chk(portb_out == 8'h18 && !sr_done, "R2", {portb_out, 7'd0, sr_done}, 32'h1800);
    // R4 invalid then idle levels are copied, nothing handled
    wr_port(8'h00);
    chk(portb_out == 8'h00 && !sr_done, "R4", {portb_out, 7'd0, sr_done}, 32'h0000);
    wr_port(8'h18);
    chk(portb_out == 8'h18 && !sr_done, "R4", {portb_out, 7'd0, sr_done}, 32'h1800);
    // R3 release from idle keeps ack high
    wr_port(8'h10);
    chk(portb_out == 8'h18 && !sr_done, "R3", {portb_out, 7'd0, sr_done}, 32'h1800);
    // R11 wrong direction in idle: ack low, no byte
    sr_dir = 1'b0;
    sr_in  = 8'h38;
    wr_port(8'h08);
    chk(portb_out == 8'h00 && !sr_done, "R11", {portb_out, 7'd0, sr_done}, 32'h0000);
    release_ack();
    run_vec(VEC[0], "R11");
    // R11 wrong direction in response phase
    host_send(8'h38);
    sr_dir = 1'b1;
    wr_port(8'h08);
    chk(!sr_done, "R11", {31'd0, sr_done}, 32'h0);
    release_ack();
    for (int j = 0; j < 4; j++) begin
      host_recv(b);
      chk(b == 8'hA0 + 8'(j), "R11", {24'd0, b}, {24'd0, 8'hA0 + 8'(j)});
    end
    // R6 zero/zero command dispatches on its own byte and returns to idle (R13 default)
    begin
      int base;
      base = n_disp;
      host_send(8'h00);
      chk(n_disp == base + 1 && last_cmd == 8'h00, "R6", n_disp, base + 1);
    end
    run_vec(VEC[1], "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule